// File: doc/BRIEF.md
# Serial Character Sync Hunter

This block watches a bit-serial synchronous receive stream and finds where characters begin. While hunting, it slides a window over the most recent received bits and compares it on every bit-clock enable against a programmed sync pattern. The pattern is either a single short sync character or a longer double-character pattern. In a third mode a level on an external pin marks the boundary instead of a pattern. Once the boundary is found, the block holds synchronization and cuts the following bits into characters of a programmed length. It presents each character with a one-cycle valid strobe.

Right after a pattern match, any further copies of the sync character are dropped silently. The first character that differs from the sync character is delivered, and from then on every character is delivered, including ones equal to the sync character. Sync characters of 5 or 7 bits are caught by programming the wider pattern as the tail of several back-to-back sync characters. The match then ends exactly on a character boundary. Synchronization is kept until the hunt command clears it.

Top module: `sync_char_hunter`

## Requirements
- R1: While reset is asserted and immediately after it is released, `in_sync` and `char_valid` are 0.
- R2: With `mode` = 00 the pattern is a single character of 8 bits (`pat_wide` = 1) or 6 bits (`pat_wide` = 0), taken from the low bits of `sync_pat`. Bit 0 of `sync_pat` is the earliest received bit. `in_sync` rises at the clock edge that samples the last pattern bit.
- R3: With `mode` = 01 the pattern is 16 bits (`pat_wide` = 1) or 12 bits (`pat_wide` = 0) of `sync_pat`, with the same bit order and acquisition timing as R2.
- R4: With `mode[1]` = 1 no pattern is used. A bit-enable cycle with `ext_sync` = 1 and `hunt` = 0 sets `in_sync` at that edge, and the next bit starts a character.
- R5: The first bit after acquisition is bit 0 of a character, and characters arrive least significant bit first. `char_len` codes 0, 1, 2, 3 select 5, 6, 7, 8 bits, and `char_data` is zero-extended. Nothing advances on cycles with `bit_en` = 0.
- R6: After a pattern acquisition, characters equal to the sync character are dropped. The sync character is the last L received bits of the pattern, that is `sync_pat[W-1 -: L]` for pattern width W and character length L. No dropping takes place after an external acquisition.
- R7: Once one character has been delivered, later characters equal to the sync character are delivered as data.
- R8: `in_sync` stays 1 until `hunt` is asserted. `hunt` clears it at the next edge, discards any partly assembled character and restarts the search.
- R9: A pattern cannot match until at least W bits have been received since reset or the last `hunt`.
- R10: A 5-bit sync character is found with an 8-bit pattern holding its last 8 bits, and a 7-bit one with a 16-bit pattern. Framing and stripping then follow R5 and R6.
- R11: `char_valid` is a single-cycle pulse at the edge that samples a character's last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Receive bit clock enable, one pulse per serial bit |
| rx_bit | input | 1 | Serial receive data, sampled when `bit_en` = 1 |
| ext_sync | input | 1 | External boundary marker used when `mode[1]` = 1 |
| hunt | input | 1 | Drop synchronization and restart the search |
| sync_pat | input | 16 | Sync pattern, bit 0 received first |
| mode | input | 2 | 00 single-character pattern, 01 double-character pattern, 1x external |
| pat_wide | input | 1 | Selects the wider of the two pattern widths of the mode |
| char_len | input | 2 | Character length code, length = code + 5 |
| in_sync | output | 1 | Character synchronization held |
| char_valid | output | 1 | One-cycle strobe for `char_data` |
| char_data | output | 8 | Assembled character, zero-extended |

## Verification
The properties assume that `mode`, `pat_wide`, `char_len` and `sync_pat` change only while the block is hunting or during a `hunt` pulse. They also assume that `hunt` and `ext_sync` are synchronous to `clk`. The stimulus therefore changes the configuration only before each `hunt` pulse. It spaces bit enables with idle cycles so that the strobe spacing and the held state are exercised between bits. Character lengths are never below 5, and the single-cycle strobe property relies on that.

// File: rtl/sync_hunt_pkg.sv
// Package: shared mode encoding for the sync hunter.
package sync_hunt_pkg;
    typedef enum logic [1:0] {
        SM_SINGLE = 2'b00,
        SM_DOUBLE = 2'b01,
        SM_EXT_A  = 2'b10,
        SM_EXT_B  = 2'b11
    } sync_mode_e;
endpackage

// File: rtl/sync_window_match.sv
// Sliding history of received bits and pattern comparator.
// Assumes the newest bit enters at the top so that the last pat_len bits
// sit in the upper part of the window, earliest bit lowest.
module sync_window_match #(
    parameter int PAT_W = 16,
    localparam int PL_W = $clog2(PAT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             rx_bit,
    input  logic             hunt,
    input  logic [PAT_W-1:0] pattern,
    input  logic [PL_W-1:0]  pat_len,
    output logic [PAT_W-1:0] win_next,
    output logic             match
);
    logic [PAT_W-1:0] win;
    logic [PL_W-1:0]  fill;
    logic [PL_W:0]    fill_inc;
    logic [PAT_W-1:0] aligned;
    logic [PAT_W-1:0] mask;
    logic             enough;

    assign win_next = {rx_bit, win[PAT_W-1:1]};
    assign fill_inc = {1'b0, fill} + {{PL_W{1'b0}}, 1'b1};
    assign enough   = fill_inc >= {1'b0, pat_len};
    assign aligned  = win_next >> (PL_W'(PAT_W) - pat_len);

    // Build the compare mask for the active pattern width.
    always_comb begin
        for (int i = 0; i < PAT_W; i++) begin
            mask[i] = PL_W'(i) < pat_len;
        end
    end

    assign match = bit_en && !hunt && enough && (((aligned ^ pattern) & mask) == '0);

    // Shift the window on each bit enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win <= '0;
        end else if (bit_en) begin
            win <= win_next;
        end
    end

    // Count bits received since reset or hunt, saturating at the window size.
    always_ff @(posedge clk) begin
        if (!rst_n || hunt) begin
            fill <= '0;
        end else if (bit_en && (fill != PL_W'(PAT_W))) begin
            fill <= fill + 1'b1;
        end
    end
endmodule

// File: rtl/sync_char_framer.sv
// Cuts the serial stream into characters once synchronization is held.
// Assumes char_len lies between 1 and CHAR_W; restart realigns the bit count.
module sync_char_framer #(
    parameter int CHAR_W = 8,
    localparam int CNT_W = $clog2(CHAR_W),
    localparam int CL_W  = $clog2(CHAR_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              active,
    input  logic              restart,
    input  logic [CL_W-1:0]   char_len,
    output logic              done,
    output logic [CHAR_W-1:0] raw_char
);
    logic [CNT_W-1:0]  cnt;
    logic [CHAR_W-1:0] asm_bits;
    logic              at_last;

    assign at_last = ({1'b0, cnt} == (char_len - 1'b1));
    assign done    = active && bit_en && !restart && at_last;

    // Merge stored bits with the bit arriving now, zeros above it.
    always_comb begin
        for (int i = 0; i < CHAR_W; i++) begin
            if (CNT_W'(i) < cnt) begin
                raw_char[i] = asm_bits[i];
            end else if (CNT_W'(i) == cnt) begin
                raw_char[i] = rx_bit;
            end else begin
                raw_char[i] = 1'b0;
            end
        end
    end

    // Track the bit position inside the current character.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (active && bit_en) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    // Store each received bit at its position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asm_bits <= '0;
        end else if (active && bit_en && !restart) begin
            asm_bits[cnt] <= rx_bit;
        end
    end
endmodule

// File: rtl/sync_strip_ctl.sv
// Holds synchronization, remembers the sync character and drops leading
// copies of it. Assumes acquire inputs are only raised while hunting.
module sync_strip_ctl #(
    parameter int PAT_W  = 16,
    parameter int CHAR_W = 8,
    localparam int PL_W  = $clog2(PAT_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hunt,
    input  logic              acq_pat,
    input  logic              acq_ext,
    input  logic [PAT_W-1:0]  win_next,
    input  logic [PL_W-1:0]   char_len,
    input  logic              done,
    input  logic [CHAR_W-1:0] raw_char,
    output logic              in_sync,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data
);
    logic [PAT_W-1:0] tail;
    logic [PAT_W-1:0] tail_mask;
    logic [PAT_W-1:0] sync_char;
    logic             leading;
    logic             is_sync;
    logic             emit;

    // Mask of the character-length tail of the matched window.
    always_comb begin
        for (int i = 0; i < PAT_W; i++) begin
            tail_mask[i] = PL_W'(i) < char_len;
        end
    end

    assign tail    = (win_next >> (PL_W'(PAT_W) - char_len)) & tail_mask;
    assign is_sync = ({{(PAT_W - CHAR_W){1'b0}}, raw_char} == sync_char);
    assign emit    = done && !(leading && is_sync);

    // Hold synchronization until a hunt command.
    always_ff @(posedge clk) begin
        if (!rst_n || hunt) begin
            in_sync <= 1'b0;
        end else if (acq_pat || acq_ext) begin
            in_sync <= 1'b1;
        end
    end

    // Capture the sync character and track the leading-sync phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_char <= '0;
            leading   <= 1'b0;
        end else if (acq_pat) begin
            sync_char <= tail;
            leading   <= 1'b1;
        end else if (acq_ext || hunt || emit) begin
            leading   <= 1'b0;
        end
    end

    // Register delivered characters and their strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_valid <= 1'b0;
            char_data  <= '0;
        end else begin
            char_valid <= emit;
            if (emit) begin
                char_data <= raw_char;
            end
        end
    end
endmodule

// File: rtl/sync_char_hunter.sv
// Top: character synchronization for a bit-serial synchronous receiver.
// Assumes configuration inputs are stable while in_sync is held.
module sync_char_hunter
    import sync_hunt_pkg::*;
#(
    parameter int PAT_W      = 16,
    parameter int CHAR_W     = 8,
    parameter int SINGLE_NAR = 6,
    parameter int SINGLE_WID = 8,
    parameter int DOUBLE_NAR = 12,
    parameter int DOUBLE_WID = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              rx_bit,
    input  logic              ext_sync,
    input  logic              hunt,
    input  logic [PAT_W-1:0]  sync_pat,
    input  logic [1:0]        mode,
    input  logic              pat_wide,
    input  logic [1:0]        char_len,
    output logic              in_sync,
    output logic              char_valid,
    output logic [CHAR_W-1:0] char_data
);
    localparam int PL_W     = $clog2(PAT_W + 1);
    localparam int CL_W     = $clog2(CHAR_W + 1);
    localparam int MIN_CHAR = CHAR_W - 3;

    sync_mode_e        mode_e;
    logic [PL_W-1:0]   pat_len;
    logic [CL_W-1:0]   clen;
    logic [PAT_W-1:0]  win_next;
    logic              match;
    logic              use_ext;
    logic              acq_pat;
    logic              acq_ext;
    logic              done;
    logic [CHAR_W-1:0] raw_char;

    assign mode_e  = sync_mode_e'(mode);
    assign use_ext = (mode_e == SM_EXT_A) || (mode_e == SM_EXT_B);
    assign clen    = CL_W'(MIN_CHAR) + CL_W'(char_len);

    // Select the pattern width from mode and width choice.
    always_comb begin
        if (mode_e == SM_DOUBLE) begin
            pat_len = pat_wide ? PL_W'(DOUBLE_WID) : PL_W'(DOUBLE_NAR);
        end else begin
            pat_len = pat_wide ? PL_W'(SINGLE_WID) : PL_W'(SINGLE_NAR);
        end
    end

    assign acq_pat = match && !use_ext && !in_sync;
    assign acq_ext = use_ext && bit_en && ext_sync && !hunt && !in_sync;

    sync_window_match #(.PAT_W(PAT_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_bit   (rx_bit),
        .hunt     (hunt),
        .pattern  (sync_pat),
        .pat_len  (pat_len),
        .win_next (win_next),
        .match    (match)
    );

    sync_char_framer #(.CHAR_W(CHAR_W)) u_framer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .rx_bit   (rx_bit),
        .active   (in_sync),
        .restart  (acq_pat || acq_ext || hunt),
        .char_len (clen),
        .done     (done),
        .raw_char (raw_char)
    );

    sync_strip_ctl #(.PAT_W(PAT_W), .CHAR_W(CHAR_W)) u_strip (
        .clk        (clk),
        .rst_n      (rst_n),
        .hunt       (hunt),
        .acq_pat    (acq_pat),
        .acq_ext    (acq_ext),
        .win_next   (win_next),
        .char_len   (PL_W'(clen)),
        .done       (done),
        .raw_char   (raw_char),
        .in_sync    (in_sync),
        .char_valid (char_valid),
        .char_data  (char_data)
    );
endmodule

// File: rtl/sync_hunter_props.sv
// Checker: temporal properties of the sync hunter ports.
module sync_hunter_props (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       ext_sync,
    input logic       hunt,
    input logic [1:0] mode,
    input logic       in_sync,
    input logic       char_valid
);
    // Sync is held while no hunt is requested.
    assert_sync_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && !hunt) |=> in_sync);

    // Hunt drops sync at the next edge.
    assert_hunt_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hunt |=> !in_sync);

    // External marker acquires sync.
    assert_ext_acquire_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && bit_en && ext_sync && !hunt) |=> in_sync);

    // Strobe lasts one cycle.
    assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid |=> !char_valid);

    // No strobe after a cycle without a bit enable.
    assert_strobe_on_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !char_valid);

    // A character is only delivered from a synchronized state.
    assert_strobe_needs_sync_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_sync || hunt) |=> !char_valid);
endmodule

bind sync_char_hunter sync_hunter_props u_props (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .ext_sync   (ext_sync),
    .hunt       (hunt),
    .mode       (mode),
    .in_sync    (in_sync),
    .char_valid (char_valid)
);

// File: tb/test_sync_char_hunter.sv
module test_sync_char_hunter;
    typedef struct packed {
        logic [1:0]  md;
        logic        wd;
        logic [1:0]  cl;
        logic [15:0] pat;
        logic [1:0]  ns;
        logic [7:0]  d0;
        logic [7:0]  d1;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [0:NV-1] = '{
        '{2'd0, 1'b1, 2'd3, 16'h0016, 2'd2, 8'hA5, 8'h16},
        '{2'd0, 1'b0, 2'd1, 16'h002B, 2'd1, 8'h15, 8'h2B},
        '{2'd1, 1'b1, 2'd3, 16'h9A3C, 2'd1, 8'h3C, 8'h55},
        '{2'd1, 1'b0, 2'd1, 16'h0B5C, 2'd2, 8'h01, 8'h2D},
        '{2'd1, 1'b1, 2'd2, 16'h972E, 2'd2, 8'h00, 8'h7F},
        '{2'd0, 1'b1, 2'd0, 16'h009C, 2'd3, 8'h0A, 8'h1F},
        '{2'd2, 1'b0, 2'd3, 16'h0016, 2'd0, 8'hC3, 8'h16}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        rx_bit = 1'b0;
    logic        ext_sync = 1'b0;
    logic        hunt = 1'b0;
    logic [15:0] sync_pat = '0;
    logic [1:0]  mode = '0;
    logic        pat_wide = 1'b0;
    logic [1:0]  char_len = '0;
    logic        in_sync;
    logic        char_valid;
    logic [7:0]  char_data;

    int checks = 0;
    int errors = 0;
    int gcount = 0;
    logic [7:0] got [0:3];
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    sync_char_hunter i_sync_char_hunter (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
        .ext_sync(ext_sync), .hunt(hunt), .sync_pat(sync_pat), .mode(mode),
        .pat_wide(pat_wide), .char_len(char_len), .in_sync(in_sync),
        .char_valid(char_valid), .char_data(char_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic e);
        @(negedge clk);
        rx_bit = b; ext_sync = e; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0; ext_sync = 1'b0;
        if (char_valid) begin
            if (gcount < 4) got[gcount] = char_data;
            gcount++;
        end
    endtask

    task automatic send_char(input logic [7:0] c, input int len);
        for (int i = 0; i < len; i++) send_bit(c[i], 1'b0);
    endtask

    task automatic do_hunt();
        @(negedge clk);
        hunt = 1'b1;
        @(negedge clk);
        hunt = 1'b0;
    endtask

    function automatic int pwidth(input logic [1:0] md, input logic wd);
        if (md == 2'd1) return wd ? 16 : 12;
        return wd ? 8 : 6;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 in_sync in reset", int'(in_sync), 0);
        chk("R1 char_valid in reset", int'(char_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_sync after reset", int'(in_sync), 0);

        // Table walk: R2 R3 R4 R5 R6 R7 R10 R11
        for (int v = 0; v < NV; v++) begin
            int w;
            int len;
            logic [15:0] sc;
            logic [7:0] lmask;
            mode = VECS[v].md; pat_wide = VECS[v].wd;
            char_len = VECS[v].cl; sync_pat = VECS[v].pat;
            do_hunt();
            gcount = 0;
            w = pwidth(VECS[v].md, VECS[v].wd);
            len = int'(VECS[v].cl) + 5;
            lmask = 8'((16'h1 << len) - 1);
            if (VECS[v].md[1]) begin
                send_bit(1'b1, 1'b0);
                send_bit(1'b0, 1'b0);
                chk("R4 not synced before marker", int'(in_sync), 0);
                send_bit(1'b1, 1'b1);
                chk("R4 synced at marker", int'(in_sync), 1);
            end else begin
                for (int b = 0; b < w - 1; b++) send_bit(VECS[v].pat[b], 1'b0);
                chk("R2/R3 not synced before last bit", int'(in_sync), 0);
                send_bit(VECS[v].pat[w-1], 1'b0);
                chk("R2 R3 R10 synced at last pattern bit", int'(in_sync), 1);
                sc = (VECS[v].pat >> (w - len)) & ((16'h1 << len) - 1);
                for (int k = 0; k < int'(VECS[v].ns); k++) send_char(sc[7:0], len);
                chk("R6 leading syncs dropped", gcount, 0);
            end
            send_char(VECS[v].d0, len);
            send_char(VECS[v].d1, len);
            chk("R5 R11 character count", gcount, 2);
            chk("R5 first character", int'(got[0]), int'(VECS[v].d0 & lmask));
            chk("R7 second character", int'(got[1]), int'(VECS[v].d1 & lmask));
        end

        // R9: all-zero pattern needs a full window
        mode = 2'd0; pat_wide = 1'b1; char_len = 2'd3; sync_pat = 16'h0000;
        do_hunt();
        gcount = 0;
        for (int b = 0; b < 7; b++) send_bit(1'b0, 1'b0);
        chk("R9 no match before 8 bits", int'(in_sync), 0);
        send_bit(1'b0, 1'b0);
        chk("R9 match at 8th bit", int'(in_sync), 1);
        send_char(8'h00, 8);
        chk("R6 zero sync char dropped", gcount, 0);
        send_char(8'h81, 8);
        chk("R5 data after sync", int'(got[0]), 8'h81);
        send_char(8'h00, 8);
        chk("R7 sync value passed as data", gcount, 2);
        chk("R8 sync held", int'(in_sync), 1);

        // R8: hunt mid-character discards it and restarts
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        do_hunt();
        chk("R8 hunt clears sync", int'(in_sync), 0);
        for (int b = 0; b < 5; b++) send_bit(1'b0, 1'b0);
        chk("R8 partial character dropped", gcount, 2);
        chk("R9 search restarted, no early match", int'(in_sync), 0);
        for (int b = 0; b < 3; b++) send_bit(1'b0, 1'b0);
        chk("R8 reacquired after hunt", int'(in_sync), 1);

        // R5: idle cycles without bit_en advance nothing
        begin
            int seen = 0;
            for (int c = 0; c < 20; c++) begin
                @(negedge clk);
                rx_bit = ~rx_bit;
                if (char_valid) seen++;
            end
            chk("R5 no strobe without bit_en", seen, 0);
        end
        gcount = 0;
        send_char(8'hF0, 8);
        chk("R5 framing kept across idle", gcount, 1);
        chk("R5 character after idle", int'(got[0]), 8'hF0);

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule